// File: doc/BRIEF.md
# SPI Sequential-Read Memory Target

This block is the target side of a serial memory that answers a single command: a continuous read. The host lowers chip select and sends an 8-bit opcode followed by a 16-bit address on the serial input. The block then streams stored bytes back on the serial output, most significant bit first, for as long as the host keeps toggling the serial clock. The address steps forward after every byte and folds back to zero past the top of the 8192-byte array.

The serial pins are sampled by a faster system clock. Two-stage synchronizers and an edge detector turn the SCK transitions into single-cycle strobes, so the whole design runs in one clock domain. Both idle-low (mode 0) and idle-high (mode 3) serial clocks are accepted. The serial output has a separate enable for an external tri-state pad; the enable is low whenever the target is deselected or has nothing to send. A synchronous write port on the system clock lets a test environment fill the array before any transfer.

Top module: `spi_read_slave`

## Requirements
- R1: A transfer begins with opcode 8'h03 and then two address bytes, high byte first, all MSB first. Each of these 24 bits is taken from `si` on a rising SCK edge.
- R2: Address bits 15 to 13 have no effect. Only bits 12 to 0 choose the byte.
- R3: The first data bit (bit 7 of the addressed byte) appears on `so` after the falling SCK edge that follows the 24th rising edge. Each later falling edge presents the next bit, MSB first.
- R4: After 8 data bits the next byte, at address plus one, follows with no idle clock in between.
- R5: The byte after address 13'h1FFF is the byte at 13'h0000, and output continues from there.
- R6: While `cs_n` is high, `so_oe` is low and `so` is 0.
- R7: `so_oe` stays low during the opcode and address phase.
- R8: Any opcode other than 8'h03 keeps `so_oe` low for the rest of that transfer. The next transfer is decoded normally.
- R9: Raising `cs_n` mid-command abandons the transfer. The next low period starts again at opcode decode.
- R10: Reads give identical data in mode 0 (SCK idle low) and mode 3 (SCK idle high).
- R11: When `wr_en` is high at a rising `clk` edge, `wr_data` is stored at `wr_addr`, and a later serial read of that address returns it.
- R12: While reset is applied, `so_oe` is low and `so` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for the external `so` pad |
| wr_en | input | 1 | Backdoor write strobe |
| wr_addr | input | 13 | Backdoor write address |
| wr_data | input | 8 | Backdoor write data |

## Verification
The checks assume that the SCK high and low times each last at least four system clocks. They also assume that `si` does not change near a rising SCK edge, and that `cs_n` changes only while SCK is quiet, several system clocks away from any SCK edge. Under these conditions every SCK transition reaches the synchronizers as one clean edge, and the state machine settles between edges. The bench drives SCK with eight-clock half periods. It changes `si` only right after a falling edge, and it holds four to eight idle clocks around every chip-select change.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
    localparam int OP_W      = 8;
    localparam int ADR_BITS  = 16;
    localparam int HDR_BITS  = OP_W + ADR_BITS;
    localparam int CNT_W     = $clog2(HDR_BITS + 1);
    localparam logic [OP_W-1:0] RD_OPCODE = 8'h03;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } rd_state_e;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int          W        = 3,
    parameter int          STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int          EDGE_BIT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic         rise_o,
    output logic         fall_o
);
    logic [W-1:0] pipe_q [STAGES];
    logic         prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
            prev_q <= RST_VAL[EDGE_BIT];
        end else begin
            pipe_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            prev_q <= pipe_q[STAGES-1][EDGE_BIT];
        end
    end

    assign sync_o = pipe_q[STAGES-1];
    assign rise_o = pipe_q[STAGES-1][EDGE_BIT] & ~prev_q;
    assign fall_o = ~pipe_q[STAGES-1][EDGE_BIT] & prev_q;
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    localparam int BPOS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              rise,
    input  logic              fall,
    input  logic              si_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              tx_bit,
    output logic              tx_oe,
    output rd_state_e         st,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(OP_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(HDR_BITS - 1);

    typedef struct packed {
        rd_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [ADR_BITS-1:0]  sh;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    tx;
        logic [BPOS_W-1:0]    bpos;
        logic                 oe;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d        = q;
        mem_re   = 1'b0;
        mem_addr = q.addr;
        if (cs_s) begin
            d.st   = ST_CMD;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.bpos = '0;
        end else begin
            unique case (q.st)
                ST_CMD: begin
                    if (rise) begin
                        d.sh  = {q.sh[ADR_BITS-2:0], si_s};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CMD_LAST)
                            d.st = ({q.sh[OP_W-2:0], si_s} == RD_OPCODE) ? ST_ADDR : ST_SKIP;
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        d.sh  = {q.sh[ADR_BITS-2:0], si_s};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == ADDR_LAST) begin
                            d.addr   = {q.sh[ADDR_W-2:0], si_s};
                            mem_re   = 1'b1;
                            mem_addr = d.addr;
                            d.st     = ST_DATA;
                            d.bpos   = '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        d.oe   = 1'b1;
                        d.bpos = q.bpos + 1'b1;
                        if (q.bpos == '0) begin
                            d.tx     = rd_data;
                            d.addr   = q.addr + 1'b1;
                            mem_re   = 1'b1;
                            mem_addr = d.addr;
                        end else begin
                            d.tx = {q.tx[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_bit = q.tx[DATA_W-1];
    assign tx_oe  = q.oe;
    assign st     = q.st;
    assign cnt    = q.cnt;
endmodule

// File: rtl/spi_read_slave.sv
module spi_read_slave
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [2:0]        pins_s;
    logic              cs_sync, sck_rise, sck_fall;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              tx_bit, tx_oe;
    rd_state_e         eng_st;
    logic [CNT_W-1:0]  eng_cnt;

    spi_rd_sync #(
        .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001), .EDGE_BIT(1)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({si, sck, cs_n}),
        .sync_o(pins_s),
        .rise_o(sck_rise),
        .fall_o(sck_fall)
    );

    assign cs_sync = pins_s[0];

    spi_rd_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk),
        .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

    spi_rd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_sync), .rise(sck_rise), .fall(sck_fall), .si_s(pins_s[2]),
        .rd_data(rd_data),
        .mem_re(rd_en), .mem_addr(rd_addr),
        .tx_bit(tx_bit), .tx_oe(tx_oe),
        .st(eng_st), .cnt(eng_cnt)
    );

    assign so_oe = tx_oe & ~cs_n;
    assign so    = so_oe & tx_bit;
endmodule

// File: rtl/spi_read_slave_chk.sv
module spi_read_slave_chk
    import spi_rd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input rd_state_e        st,
    input logic [CNT_W-1:0] cnt,
    input logic             fall,
    input logic             cs_s,
    input logic             so,
    input logic             so_oe
);
    // R7: no drive while opcode or address bits are arriving
    p_quiet_header_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD || st == ST_ADDR) |-> !so_oe);

    // R8: rejected opcode never drives the pad
    p_quiet_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !so_oe);

    // R3: output bit only moves right after a falling SCK strobe
    p_launch_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so != $past(so))) |-> $past(fall));

    // R1: header counter never runs past 24 bits
    p_hdr_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(HDR_BITS));

    // R6: synchronized deselect clears the drive enable
    p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe);
endmodule

bind spi_read_slave spi_read_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(eng_st), .cnt(eng_cnt),
    .fall(sck_fall), .cs_s(cs_sync), .so(so), .so_oe(so_oe)
);

// File: tb/tb_spi_read_slave.sv
`timescale 1ns/1ps
module tb_spi_read_slave;
    localparam int HALF = 8;
    localparam int NVEC = 6;
    // [31] mode3, [23:8] address, [7:0] byte count
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 7'd0, 16'h0000, 8'd3},
        {1'b1, 7'd0, 16'h0123, 8'd4},
        {1'b0, 7'd0, 16'hE456, 8'd2},
        {1'b1, 7'd0, 16'h1FFE, 8'd4},
        {1'b0, 7'd0, 16'h0FFF, 8'd9},
        {1'b1, 7'd0, 16'hFFFF, 8'd2}
    };

    logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
    logic so, so_oe, wr_en = 0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rx [16];
    logic oe_hdr, oe_any, oe_data_ok;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_read_slave dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b000} ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit m3, input logic [7:0] op, input logic [15:0] a,
                        input int nb, input int stop_at);
        logic [23:0] hdr;
        int nbits;
        hdr = {op, a};
        nbits = (stop_at > 0) ? stop_at : 24 + 8 * nb;
        oe_hdr = 0; oe_any = 0; oe_data_ok = 1;
        @(negedge clk) sck = m3;
        repeat (4) @(negedge clk);
        cs_n = 0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 0;
            si  = (i < 24) ? hdr[23 - i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (so_oe) oe_any = 1;
            if (i < 24 && so_oe) oe_hdr = 1;
            if (i >= 24) begin
                if (!so_oe) oe_data_ok = 0;
                rx[(i - 24) / 8][7 - ((i - 24) % 8)] = so;
            end
            sck = 1;
            repeat (HALF) @(negedge clk);
        end
        if (!m3) sck = 0;
        repeat (4) @(negedge clk);
        cs_n = 1;
        @(negedge clk);
        chk(!so_oe && !so, "R6 deselect hi-Z", {so_oe, so}, 0);
        repeat (8) @(negedge clk);
    endtask

    task automatic check_read(input bit m3, input logic [15:0] a, input int nb, input string tag);
        xfer(m3, 8'h03, a, nb, 0);
        chk(!oe_hdr, {tag, " R7 oe low in header"}, oe_hdr, 0);
        chk(oe_data_ok, {tag, " R3 oe high in data"}, oe_data_ok, 1);
        for (int k = 0; k < nb; k++) begin
            logic [12:0] ea;
            ea = a[12:0] + 13'(k);
            chk(rx[k] == pat(ea), {tag, " R1 R3 R4 byte"}, rx[k], pat(ea));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!so_oe && !so, "R12 reset state", {so_oe, so}, 0);
        rst_n = 1;
        for (int a = 0; a < 8192; a++) begin
            @(negedge clk) wr_en = 1; wr_addr = 13'(a); wr_data = pat(13'(a));
        end
        @(negedge clk) wr_en = 0;
        repeat (4) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            check_read(VEC[v][31], VEC[v][23:8], int'(VEC[v][7:0]),
                       $sformatf("vec%0d R10 R2 R5", v));
        end

        // R8: bad opcode never drives, next transfer decodes normally
        xfer(1'b0, 8'h0B, 16'h0010, 2, 0);
        chk(!oe_any, "R8 rejected opcode quiet", oe_any, 0);
        check_read(1'b0, 16'h0010, 2, "R8 follow-up");

        // R9: abort mid-address, restart cleanly
        xfer(1'b1, 8'h03, 16'h0ABC, 0, 12);
        chk(!oe_any, "R9 aborted transfer quiet", oe_any, 0);
        check_read(1'b1, 16'h0ABC, 2, "R9 restart");

        // R5: explicit wrap value 1FFF -> 0000
        xfer(1'b0, 8'h03, 16'h1FFF, 2, 0);
        chk(rx[1] == pat(13'h0000), "R5 wrap to zero", rx[1], pat(13'h0000));

        // R11: backdoor write then serial read
        @(negedge clk) wr_en = 1; wr_addr = 13'h0777; wr_data = 8'hA5;
        @(negedge clk) wr_en = 0;
        repeat (4) @(negedge clk);
        xfer(1'b1, 8'h03, 16'h0777, 2, 0);
        chk(rx[0] == 8'hA5, "R11 backdoor byte", rx[0], 8'hA5);
        chk(rx[1] == pat(13'h0778), "R11 neighbour byte", rx[1], pat(13'h0778));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule